// File: doc/BRIEF.md
# Interrupt State Bank

This block keeps the per-interrupt state of an interrupt distributor. For each interrupt it holds an enable bit, a pending bit, an active bit, a trigger mode (edge or level), a software-pending latch and a priority byte. Software reaches that state through a plain register-access port. Each access carries an address, a byte count of 1 to 4, write data and a write flag. The enable, pending and active vectors leave the block as flat outputs for the arbitration logic that sits downstream.

Each interrupt has an input line that carries its current level. An edge-triggered interrupt becomes pending on a rising edge of its line. A level-triggered interrupt takes its pending bit from two terms: the live line level and the software-pending latch. Clear-pending writes and trigger-configuration writes recompute the pending bit from those two terms. Interrupts numbered below NUM_PRIV are private. Their trigger mode is fixed as level and cannot be written.

Top module: `irq_state_bank`

## Requirements
- R1: After reset every interrupt is disabled, inactive and not pending, and its priority is 0. Interrupts below NUM_PRIV come up level-triggered and all other interrupts come up edge-triggered.
- R2: The top three address bits select a region: 0 enable-set, 1 enable-clear, 2 pending-set, 3 pending-clear, 4 active-set, 5 active-clear, 6 trigger configuration, 7 priority. The low OFF_W address bits are the register offset. An access covers acc_len bytes (1 to 4), taken from data bit 0 upward.
- R3: In regions 0 to 5, data bit b refers to interrupt offset*8+b. A read of either region of a pair returns that pair's state vector. Bits beyond acc_len*8, and bits that name no interrupt, read 0. Read data appears on acc_rdata on the clock edge after the read strobe and holds until the next read.
- R4: In the set and clear regions only data bits written as 1 act. A 1 to enable-set or active-set sets the bit, and a 1 to enable-clear or active-clear clears it.
- R5: A 1 to pending-set makes the interrupt pending. On a level-triggered interrupt it also sets the software-pending latch.
- R6: A 1 to pending-clear on a level-triggered interrupt clears the latch and loads pending with the current line level. On an edge-triggered interrupt it clears pending.
- R7: On an edge-triggered interrupt, a rising line sets pending one clock later. On a level-triggered interrupt, any line change loads pending with line OR latch.
- R8: In region 6 interrupt offset*4+i owns data bits [2i+1:2i]. A read returns binary 10 for edge-triggered and 00 for level-triggered.
- R9: A region-6 write selects edge when bit 2i+1 is 1 and level when it is 0. Selecting level loads pending with line OR latch.
- R10: Region-6 writes to interrupts below NUM_PRIV have no effect.
- R11: In region 7 byte lane i refers to interrupt offset+i. A write stores the byte with the low 8-PRI_BITS bits forced to 0, and a read returns the stored bytes.
- R12: When a write and a line change land in the same cycle, both are applied, and the write decides the bits it touches.
- R13: irq_enabled, irq_pending and irq_active show the stored state of every interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | OFF_W+3 | Region in top three bits, offset below |
| acc_len | input | 3 | Bytes in the access, 1 to 4 |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| irq_line | input | NUM_IRQ | Current level of each interrupt line |
| irq_enabled | output | NUM_IRQ | Enable state vector |
| irq_pending | output | NUM_IRQ | Pending state vector |
| irq_active | output | NUM_IRQ | Active state vector |

## Verification
The bench builds the block with NUM_IRQ=16, NUM_PRIV=8 and PRI_BITS=3. With these values every state vector fits in one 32-bit access, and offsets sweep past the last interrupt. The private/shared boundary sits inside a single configuration word, so a single write tests both the locked fields and the open ones. The 3-bit priority leaves five low bits that must read back as zero. Line patterns, set and clear writes of every length, and trigger changes are mixed on the same interrupts. This drives the latch-plus-line pending rule through rises, falls and changes of mode.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

   localparam int ACC_BYTES = 4;
   localparam int ACC_W     = 8 * ACC_BYTES;

   typedef enum logic [2:0] {
      RG_SET_EN  = 3'd0,
      RG_CLR_EN  = 3'd1,
      RG_SET_PND = 3'd2,
      RG_CLR_PND = 3'd3,
      RG_SET_ACT = 3'd4,
      RG_CLR_ACT = 3'd5,
      RG_TRIG    = 3'd6,
      RG_PRIO    = 3'd7
   } reg_region_e;

   typedef struct packed {
      logic       en_set;
      logic       en_clr;
      logic       pnd_set;
      logic       pnd_clr;
      logic       act_set;
      logic       act_clr;
      logic       trig_wr;
      logic       trig_edge;
      logic       prio_wr;
      logic [7:0] prio_byte;
   } irq_cmd_t;

   function automatic logic lane_hit(input int rel, input int span);
      return (rel >= 0) && (rel < span);
   endfunction

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
   import irq_bank_pkg::*;
#(
   parameter int NUM_IRQ  = 64,
   parameter int NUM_PRIV = 32,
   parameter int OFF_W    = 6
) (
   input  logic             wr_en,
   input  reg_region_e      region,
   input  logic [OFF_W-1:0] offset,
   input  logic [2:0]       nbytes,
   input  logic [ACC_W-1:0] wdata,
   output irq_cmd_t         cmd [NUM_IRQ]
);

   for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
      int       rb, rc, rp;
      logic     bhit, chit, phit;
      logic [4:0] bsel;
      logic [3:0] csel;
      logic [1:0] psel;
      logic     trig_sel;
      irq_cmd_t c;

      always_comb begin
         rb   = gi - int'(offset) * 8;
         rc   = gi - int'(offset) * 4;
         rp   = gi - int'(offset);
         bhit = lane_hit(rb, int'(nbytes) * 8);
         chit = lane_hit(rc, int'(nbytes) * 4);
         phit = lane_hit(rp, int'(nbytes));
         bsel = 5'(rb);
         csel = 4'(rc);
         psel = 2'(rp);
      end

      // private interrupts never accept a trigger-mode write (R10)
      if (gi < NUM_PRIV) begin : g_lock
         assign trig_sel = 1'b0;
      end else begin : g_open
         assign trig_sel = chit;
      end

      always_comb begin
         c           = '0;
         c.prio_byte = wdata[8*psel +: 8];
         c.trig_edge = wdata[2*csel + 1];
         if (wr_en) begin
            unique case (region)
               RG_SET_EN:  c.en_set  = bhit & wdata[bsel];
               RG_CLR_EN:  c.en_clr  = bhit & wdata[bsel];
               RG_SET_PND: c.pnd_set = bhit & wdata[bsel];
               RG_CLR_PND: c.pnd_clr = bhit & wdata[bsel];
               RG_SET_ACT: c.act_set = bhit & wdata[bsel];
               RG_CLR_ACT: c.act_clr = bhit & wdata[bsel];
               RG_TRIG:    c.trig_wr = trig_sel;
               RG_PRIO:    c.prio_wr = phit;
               default:    ;
            endcase
         end
      end

      assign cmd[gi] = c;
   end

endmodule

// File: rtl/irq_cell.sv
module irq_cell
   import irq_bank_pkg::*;
#(
   parameter int PRI_BITS = 5,
   parameter bit EDGE_RST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line,
   input  irq_cmd_t   cmd,
   output logic       en_o,
   output logic       pend_o,
   output logic       act_o,
   output logic       edge_o,
   output logic [7:0] prio_o
);

   localparam int         PRI_SH   = 8 - PRI_BITS;
   localparam logic [7:0] PRI_MASK = 8'(9'h0FF << PRI_SH);

   logic en_q, pend_q, act_q, edge_q, soft_q, line_q;
   logic en_d, pend_d, act_d, edge_d, soft_d;
   logic [7:0] prio_q, prio_d;

   always_comb begin
      en_d   = en_q;
      act_d  = act_q;
      pend_d = pend_q;
      soft_d = soft_q;
      edge_d = edge_q;
      prio_d = prio_q;

      // line activity first; a write below overrides the bits it touches
      if (edge_q) begin
         if (line && !line_q) pend_d = 1'b1;
      end else if (line != line_q) begin
         pend_d = line | soft_q;
      end

      if (cmd.en_set)  en_d  = 1'b1;
      if (cmd.en_clr)  en_d  = 1'b0;
      if (cmd.act_set) act_d = 1'b1;
      if (cmd.act_clr) act_d = 1'b0;

      if (cmd.pnd_set) begin
         pend_d = 1'b1;
         if (!edge_q) soft_d = 1'b1;
      end
      if (cmd.pnd_clr) begin
         if (edge_q) begin
            pend_d = 1'b0;
         end else begin
            soft_d = 1'b0;
            pend_d = line;
         end
      end

      if (cmd.trig_wr) begin
         edge_d = cmd.trig_edge;
         if (!cmd.trig_edge) pend_d = line | soft_q;
      end

      if (cmd.prio_wr) prio_d = cmd.prio_byte & PRI_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         pend_q <= 1'b0;
         act_q  <= 1'b0;
         soft_q <= 1'b0;
         line_q <= 1'b0;
         edge_q <= EDGE_RST;
         prio_q <= '0;
      end else begin
         en_q   <= en_d;
         pend_q <= pend_d;
         act_q  <= act_d;
         soft_q <= soft_d;
         line_q <= line;
         edge_q <= edge_d;
         prio_q <= prio_d;
      end
   end

   assign en_o   = en_q;
   assign pend_o = pend_q;
   assign act_o  = act_q;
   assign edge_o = edge_q;
   assign prio_o = prio_q;

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
   import irq_bank_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int OFF_W   = 6
) (
   input  reg_region_e        region,
   input  logic [OFF_W-1:0]   offset,
   input  logic [2:0]         nbytes,
   input  logic [NUM_IRQ-1:0] en_vec,
   input  logic [NUM_IRQ-1:0] pend_vec,
   input  logic [NUM_IRQ-1:0] act_vec,
   input  logic [NUM_IRQ-1:0] edge_vec,
   input  logic [NUM_IRQ*8-1:0] prio_flat,
   output logic [ACC_W-1:0]   rdata
);

   localparam int FIELDS = ACC_W / 2;

   logic [NUM_IRQ-1:0] sel_vec;

   always_comb begin
      unique case (region)
         RG_SET_EN,  RG_CLR_EN:  sel_vec = en_vec;
         RG_SET_PND, RG_CLR_PND: sel_vec = pend_vec;
         RG_SET_ACT, RG_CLR_ACT: sel_vec = act_vec;
         default:                sel_vec = '0;
      endcase
   end

   always_comb begin
      int idx;
      rdata = '0;
      idx   = 0;
      unique case (region)
         RG_TRIG: begin
            for (int f = 0; f < FIELDS; f++) begin
               idx = int'(offset) * 4 + f;
               if (f < int'(nbytes) * 4 && idx < NUM_IRQ)
                  rdata[2*f + 1] = edge_vec[idx];
            end
         end
         RG_PRIO: begin
            for (int p = 0; p < ACC_BYTES; p++) begin
               idx = int'(offset) + p;
               if (p < int'(nbytes) && idx < NUM_IRQ)
                  rdata[8*p +: 8] = prio_flat[8*idx +: 8];
            end
         end
         default: begin
            for (int b = 0; b < ACC_W; b++) begin
               idx = int'(offset) * 8 + b;
               if (b < int'(nbytes) * 8 && idx < NUM_IRQ)
                  rdata[b] = sel_vec[idx];
            end
         end
      endcase
   end

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
   import irq_bank_pkg::*;
#(
   parameter int  NUM_IRQ  = 64,
   parameter int  NUM_PRIV = 32,
   parameter int  PRI_BITS = 5,
   localparam int OFF_W    = $clog2(NUM_IRQ),
   localparam int ADDR_W   = OFF_W + 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [2:0]         acc_len,
   input  logic [ACC_W-1:0]   acc_wdata,
   output logic [ACC_W-1:0]   acc_rdata,
   input  logic [NUM_IRQ-1:0] irq_line,
   output logic [NUM_IRQ-1:0] irq_enabled,
   output logic [NUM_IRQ-1:0] irq_pending,
   output logic [NUM_IRQ-1:0] irq_active
);

   if (NUM_IRQ < 8 || (NUM_IRQ % 8) != 0) begin : g_bad_num
      $error("NUM_IRQ must be a multiple of 8, at least 8");
   end
   if (NUM_PRIV < 0 || NUM_PRIV > NUM_IRQ) begin : g_bad_priv
      $error("NUM_PRIV must lie in 0..NUM_IRQ");
   end
   if (PRI_BITS < 1 || PRI_BITS > 8) begin : g_bad_pri
      $error("PRI_BITS must lie in 1..8");
   end

   reg_region_e        region;
   logic [OFF_W-1:0]   offset;
   logic [2:0]         nbytes;
   irq_cmd_t           cmd [NUM_IRQ];
   logic [NUM_IRQ-1:0] edge_vec;
   logic [NUM_IRQ*8-1:0] prio_flat;
   logic [ACC_W-1:0]   rd_next;

   assign region = reg_region_e'(acc_addr[ADDR_W-1 -: 3]);
   assign offset = acc_addr[OFF_W-1:0];
   assign nbytes = (acc_len > 3'(ACC_BYTES)) ? 3'(ACC_BYTES) : acc_len;

   irq_wr_decode #(
      .NUM_IRQ  (NUM_IRQ),
      .NUM_PRIV (NUM_PRIV),
      .OFF_W    (OFF_W)
   ) u_dec (
      .wr_en  (acc_valid & acc_write),
      .region (region),
      .offset (offset),
      .nbytes (nbytes),
      .wdata  (acc_wdata),
      .cmd    (cmd)
   );

   for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_cell
      irq_cell #(
         .PRI_BITS (PRI_BITS),
         .EDGE_RST ((gi < NUM_PRIV) ? 1'b0 : 1'b1)
      ) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .line   (irq_line[gi]),
         .cmd    (cmd[gi]),
         .en_o   (irq_enabled[gi]),
         .pend_o (irq_pending[gi]),
         .act_o  (irq_active[gi]),
         .edge_o (edge_vec[gi]),
         .prio_o (prio_flat[8*gi +: 8])
      );
   end

   irq_rd_mux #(
      .NUM_IRQ (NUM_IRQ),
      .OFF_W   (OFF_W)
   ) u_rd (
      .region    (region),
      .offset    (offset),
      .nbytes    (nbytes),
      .en_vec    (irq_enabled),
      .pend_vec  (irq_pending),
      .act_vec   (irq_active),
      .edge_vec  (edge_vec),
      .prio_flat (prio_flat),
      .rdata     (rd_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      acc_rdata <= '0;
      else if (acc_valid && !acc_write) acc_rdata <= rd_next;
   end

endmodule

// File: rtl/irq_state_bank_chk.sv
module irq_state_bank_chk #(
   parameter int NUM_IRQ = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               acc_valid,
   input logic               acc_write,
   input logic [2:0]         rg,
   input logic [31:0]        acc_rdata,
   input logic [NUM_IRQ-1:0] irq_enabled,
   input logic [NUM_IRQ-1:0] irq_pending,
   input logic [NUM_IRQ-1:0] irq_active
);

   logic wr, rd;
   assign wr = acc_valid & acc_write;
   assign rd = acc_valid & ~acc_write;

   // R3: read data only moves after a read strobe
   p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(acc_rdata));

   // R4: enables move only on enable-region writes
   p_en_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && (rg == 3'd0 || rg == 3'd1)) |=> $stable(irq_enabled));

   // R4: active bits move only on active-region writes
   p_act_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && (rg == 3'd4 || rg == 3'd5)) |=> $stable(irq_active));

   // R4: enable-set never clears a bit
   p_en_set_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && rg == 3'd0) |=> (($past(irq_enabled) & ~irq_enabled) == '0));

   // R4: active-clear never sets a bit
   p_act_clr_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && rg == 3'd5) |=> ((irq_active & ~$past(irq_active)) == '0));

   // R13: pending vector never holds an unknown value
   p_pend_known_r13: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> !$isunknown(irq_pending));

endmodule

bind irq_state_bank irq_state_bank_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_valid   (acc_valid),
   .acc_write   (acc_write),
   .rg          (acc_addr[ADDR_W-1 -: 3]),
   .acc_rdata   (acc_rdata),
   .irq_enabled (irq_enabled),
   .irq_pending (irq_pending),
   .irq_active  (irq_active)
);

// File: tb/irq_state_bank_tb.sv
`timescale 1ns/1ps
module irq_state_bank_tb;

   localparam int N   = 16;
   localparam int NP  = 8;
   localparam int PB  = 3;
   localparam int OW  = $clog2(N);
   localparam int AW  = OW + 3;
   localparam int OFS = 1 << OW;
   localparam logic [7:0] PMASK = 8'(9'h0FF << (8 - PB));

   logic          clk = 1'b0;
   logic          rst_n;
   logic          acc_valid, acc_write;
   logic [AW-1:0] acc_addr;
   logic [2:0]    acc_len;
   logic [31:0]   acc_wdata;
   logic [31:0]   acc_rdata;
   logic [N-1:0]  irq_line;
   logic [N-1:0]  irq_enabled, irq_pending, irq_active;

   irq_state_bank #(.NUM_IRQ(N), .NUM_PRIV(NP), .PRI_BITS(PB)) u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_len(acc_len), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .irq_line(irq_line), .irq_enabled(irq_enabled),
      .irq_pending(irq_pending), .irq_active(irq_active));

   always #10 clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   logic [N-1:0] m_en, m_pend, m_act, m_edge, m_soft, m_lineq;
   logic [7:0]   m_pri [N];

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic chk_vecs(input string req);
      chk(req, "enable vector",  32'(irq_enabled), 32'(m_en));
      chk(req, "pending vector", 32'(irq_pending), 32'(m_pend));
      chk(req, "active vector",  32'(irq_active),  32'(m_act));
   endtask

   function automatic logic [31:0] model_read(input int rg, input int off, input int len);
      logic [31:0] v = '0;
      logic [N-1:0] sv;
      sv = (rg < 2) ? m_en : (rg < 4) ? m_pend : m_act;
      if (rg < 6) begin
         for (int b = 0; b < 32; b++)
            if (b < len*8 && off*8 + b < N) v[b] = sv[off*8 + b];
      end else if (rg == 6) begin
         for (int f = 0; f < 16; f++)
            if (f < len*4 && off*4 + f < N) v[2*f+1] = m_edge[off*4 + f];
      end else begin
         for (int p = 0; p < 4; p++)
            if (p < len && off + p < N) v[8*p +: 8] = m_pri[off + p];
      end
      return v;
   endfunction

   task automatic model_step(input bit wr, input int rg, input int off, input int len,
                             input logic [31:0] d, input logic [N-1:0] ln);
      for (int i = 0; i < N; i++) begin
         int  rb = i - off*8;
         int  rc = i - off*4;
         int  rp = i - off;
         bit  bh = (rb >= 0) && (rb < len*8) && d[rb & 31];
         // R7 line activity, then the write decides touched bits (R12)
         if (m_edge[i]) begin
            if (ln[i] && !m_lineq[i]) m_pend[i] = 1'b1;
         end else if (ln[i] != m_lineq[i]) begin
            m_pend[i] = ln[i] | m_soft[i];
         end
         if (wr) begin
            case (rg)
               0: if (bh) m_en[i]  = 1'b1;
               1: if (bh) m_en[i]  = 1'b0;
               4: if (bh) m_act[i] = 1'b1;
               5: if (bh) m_act[i] = 1'b0;
               2: if (bh) begin
                     m_pend[i] = 1'b1;
                     if (!m_edge[i]) m_soft[i] = 1'b1;
                  end
               3: if (bh) begin
                     if (m_edge[i]) m_pend[i] = 1'b0;
                     else begin m_soft[i] = 1'b0; m_pend[i] = ln[i]; end
                  end
               6: if (rc >= 0 && rc < len*4 && i >= NP) begin
                     m_edge[i] = d[(2*rc + 1) & 31];
                     if (!m_edge[i]) m_pend[i] = ln[i] | m_soft[i];
                  end
               default: if (rp >= 0 && rp < len) m_pri[i] = d[8*(rp & 3) +: 8] & PMASK;
            endcase
         end
      end
      m_lineq = ln;
   endtask

   // called at a negedge; returns at the next negedge
   task automatic access(input bit wr, input int rg, input int off, input int len,
                         input logic [31:0] d, input logic [N-1:0] ln,
                         output logic [31:0] rd);
      acc_valid = 1'b1;
      acc_write = wr;
      acc_addr  = AW'(rg*OFS + off);
      acc_len   = 3'(len);
      acc_wdata = d;
      irq_line  = ln;
      @(negedge clk);
      acc_valid = 1'b0;
      rd = acc_rdata;
      model_step(wr, rg, off, len, d, ln);
   endtask

   task automatic wr_op(input int rg, input int off, input int len, input logic [31:0] d);
      logic [31:0] junk;
      access(1'b1, rg, off, len, d, irq_line, junk);
   endtask

   task automatic rd_chk(input string req, input int rg, input int off, input int len);
      logic [31:0] exp, got;
      exp = model_read(rg, off, len);
      access(1'b0, rg, off, len, 32'h0, irq_line, got);
      chk(req, $sformatf("read region %0d offset %0d len %0d", rg, off, len), got, exp);
   endtask

   task automatic line_step(input logic [N-1:0] ln);
      irq_line = ln;
      @(negedge clk);
      model_step(1'b0, 0, 0, 0, 32'h0, ln);
   endtask

   function automatic logic [31:0] pat(input int k);
      return {8'(k*37 + 5), 8'(~k), 8'(k ^ 'h5A), 8'(k + 195)};
   endfunction

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int k;
      logic [31:0] junk;
      rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
      acc_len = 3'd4; acc_wdata = '0; irq_line = '0;
      m_en = '0; m_pend = '0; m_act = '0; m_soft = '0; m_lineq = '0;
      for (int i = 0; i < N; i++) begin
         m_edge[i] = (i >= NP);
         m_pri[i]  = 8'h00;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_vecs("R1");
      chk("R1", "trigger word at reset", model_read(6, 0, 4), 32'hAAAA_0000);
      rd_chk("R1", 6, 0, 4);
      rd_chk("R1", 7, 0, 4);
      rd_chk("R1", 7, 12, 4);

      // R2 R3 R4 R5 R6: set/clear regions, every length, offsets past the end
      k = 0;
      for (int rg = 0; rg < 6; rg++) begin
         for (int off = 0; off < 3; off++) begin
            for (int li = 0; li < 3; li++) begin
               int len = (li == 2) ? 4 : li + 1;
               wr_op(rg, off, len, pat(k));
               k++;
               chk_vecs(rg == 2 ? "R5" : rg == 3 ? "R6" : "R4");
               rd_chk("R3", rg & 6, 0, 2);
               rd_chk("R3", rg | 1, 1, 1);
               rd_chk("R2", rg, off, len);
            end
         end
      end
      wr_op(0, 0, 2, 32'h0);
      chk_vecs("R4");

      // R7 line patterns mixed with pending writes
      for (int j = 0; j < 14; j++) begin
         line_step(16'((j * 12059) ^ (j << 5)));
         chk_vecs("R7");
         if (j % 3 == 0) begin wr_op(2, 0, 2, pat(j + 40)); chk_vecs("R5"); end
         if (j % 4 == 1) begin wr_op(3, 0, 2, pat(j + 60)); chk_vecs("R6"); end
      end

      // R8 R9 trigger configuration sweep
      for (int off = 0; off < 4; off++) begin
         for (int li = 0; li < 2; li++) begin
            wr_op(6, off, li + 1, pat(off*5 + li + 90));
            chk_vecs("R9");
            rd_chk("R8", 6, 0, 4);
            rd_chk("R8", 6, off, li + 1);
         end
         line_step(~irq_line);
         chk_vecs("R7");
      end

      // R10 private fields stay level
      wr_op(6, 0, 4, 32'hFFFF_FFFF);
      rd_chk("R10", 6, 0, 4);
      chk("R10", "private trigger bits", model_read(6, 0, 2) & 32'h0000_AAAA, 32'h0);
      wr_op(2, 0, 1, 32'h01);
      line_step(irq_line ^ 16'h0001);
      chk_vecs("R10");
      wr_op(6, 0, 4, 32'h0);
      chk_vecs("R9");
      rd_chk("R10", 6, 0, 4);

      // R11 priority lanes and masking
      for (int off = 0; off < N; off++) begin
         wr_op(7, off, (off % 3 == 2) ? 4 : (off % 3) + 1, pat(off + 120));
      end
      for (int off = 0; off < N; off += 4) rd_chk("R11", 7, off, 4);
      rd_chk("R11", 7, 15, 4);
      rd_chk("R11", 7, 3, 2);

      // R12 write versus line in the same cycle
      wr_op(6, 3, 1, 32'h0000_00AA);
      line_step(irq_line & ~16'h1000);
      access(1'b1, 3, 1, 1, 32'h10, irq_line | 16'h1000, junk);
      chk("R12", "pending bit 12", 32'(irq_pending[12]), 32'h0);
      chk_vecs("R12");
      line_step(irq_line | 16'h0008);
      access(1'b1, 2, 0, 1, 32'h08, irq_line & ~16'h0008, junk);
      chk("R12", "pending bit 3", 32'(irq_pending[3]), 32'h1);
      chk_vecs("R12");

      // R9 switch to level with line high
      wr_op(6, 3, 1, 32'h0);
      chk_vecs("R9");
      chk_vecs("R13");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule